// File: doc/BRIEF.md
# Cascadable Multiply-Accumulate Arithmetic Slice

This block is a pipelined signed arithmetic unit meant to be tiled into filters, wide multipliers and accumulators. An 18 by 18 two's-complement multiplier feeds a 48-bit three-input post-adder. The post-adder can also take its own registered result, the result of a neighbouring slice, or that neighbouring result arithmetically shifted right by 17 places. The shifted form lines up partial products when a wide multiplication is split across several slices.

A 6-bit operation word is sampled alongside the operands on every cycle. It picks the three adder operands and chooses between addition and subtraction, so one slice can act as a plain multiplier, a MAC, a multiply-add or multiply-subtract, a three-input adder or an accumulator. The choice can change on any cycle. The B operand is passed on through one register to the next slice, and the result is passed on unchanged. Symmetric rounding comes from a rounding constant on the C input plus the carry input. Each pipeline stage is kept or removed by a parameter. Control registers and data registers have separate synchronous resets and separate clock enables.

Top module: `mac_slice`

## Requirements
- R1: With op[1:0]=1 (product), op[2]=0, op[4:3]=0 and op[5]=0, the result equals the signed product of A and B sign-extended to 48 bits, including the case of both operands at -131072.
- R2: The result is Z + X + Y + cin when op[5]=0 and Z - (X + Y + cin) when op[5]=1, modulo 2^48. X comes from op[1:0] (0 zero, 1 product, 2 own result, 3 zero), Y from op[2] (0 zero, 1 C) and Z from op[4:3] (0 zero, 1 own result, 2 cascade input, 3 cascade input shifted).
- R3: Selecting the own registered result as X or Z accumulates: with op[4:3]=1 each product is added to the previous result, and with op[1:0]=2, op[2]=1 each C is added to it.
- R4: With op[4:3]=2 the cascade input enters the adder unshifted, in the cycle the result register loads.
- R5: With op[4:3]=3 the cascade input enters the adder arithmetically shifted right by 17 bits, with the sign bit replicated.
- R6: With the B register enabled, the B cascade output equals the B operand captured at the previous enabled clock edge.
- R7: With all stages enabled, the operands and operation word applied in cycle n produce the result visible after clock edge n+2, which is three edges counting the one that captures them. The operation word may differ on every cycle.
- R8: With C = 7 and cin equal to 1 for a non-negative product and 0 for a negative one, bits 47:4 of the result give the product divided by 16, rounded to nearest with ties away from zero.
- R9: Asserting both resets clears the result and the B cascade output to zero at the next edge, and the result stays zero until non-zero work reaches it.
- R10: While both clock enables are low, the result and the B cascade output hold their values whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_ctl | input | 1 | Synchronous reset of the operation-word and carry registers |
| rst_dat | input | 1 | Synchronous reset of the operand, product and result registers |
| ce_ctl | input | 1 | Clock enable of the control registers |
| ce_dat | input | 1 | Clock enable of the data registers |
| a | input | 18 | Multiplier operand A, signed |
| b | input | 18 | Multiplier operand B, signed |
| c | input | 48 | Wide addend or rounding constant |
| bcin | input | 18 | B operand from the previous slice |
| pcin | input | 48 | Result from the previous slice |
| op | input | 6 | Operation word: [1:0] X select, [2] Y select, [4:3] Z select, [5] subtract |
| cin | input | 1 | Carry into the post-adder |
| p | output | 48 | Registered result |
| bcout | output | 18 | Registered B operand passed to the next slice |
| pcout | output | 48 | Result passed to the next slice |

## Verification
The slice is first tried with pure products at the operand extremes, which separates correct sign extension from zero extension. Runs of accumulation show whether feedback uses the registered result or the incoming product. Cascade traffic with the sign bit set, applied unshifted and shifted, shows the difference between arithmetic and logical shifting and any offset in the shift amount. A stretch where the operation word changes on every cycle shows whether the control stays aligned with its operands through the pipeline. Rounding ties of both signs separate symmetric rounding from round-half-up.

// File: rtl/mac_slice_pkg.sv
package mac_slice_pkg;

   typedef enum logic [1:0] {
      X_ZERO = 2'd0,
      X_PROD = 2'd1,
      X_PFB  = 2'd2,
      X_RSVD = 2'd3
   } xsel_e;

   typedef enum logic [1:0] {
      Z_ZERO     = 2'd0,
      Z_PFB      = 2'd1,
      Z_CASC     = 2'd2,
      Z_CASC_SHR = 2'd3
   } zsel_e;

   typedef struct packed {
      logic  sub;
      zsel_e zsel;
      logic  ysel;
      xsel_e xsel;
   } op_t;

   localparam int OP_W  = $bits(op_t);
   localparam int CTL_W = OP_W + 1;

endpackage

// File: rtl/mac_pipe_reg.sv
module mac_pipe_reg #(
   parameter int W  = 1,
   parameter bit EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         ce,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_width
      $error("mac_pipe_reg: W must be at least 1");
   end

   if (EN) begin : g_reg
      logic [W-1:0] r;
      always_ff @(posedge clk) begin
         if (rst)     r <= '0;
         else if (ce) r <= d;
      end
      assign q = r;
   end else begin : g_wire
      logic unused_bits;
      assign unused_bits = ^{clk, rst, ce};
      assign q = d;
   end

endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
   parameter int A_W   = 18,
   parameter int B_W   = 18,
   parameter int P_W   = 48,
   parameter bit M_REG = 1'b1
) (
   input  logic           clk,
   input  logic           rst_dat,
   input  logic           ce_dat,
   input  logic [A_W-1:0] a,
   input  logic [B_W-1:0] b,
   output logic [P_W-1:0] m
);

   localparam int PROD_W = A_W + B_W;
   localparam int EXT_W  = P_W - PROD_W;

   if (EXT_W < 1) begin : g_bad_width
      $error("mac_mult: P_W must exceed A_W + B_W");
   end

   logic signed [PROD_W-1:0] prod;
   logic        [P_W-1:0]    prod_ext;

   assign prod     = $signed(a) * $signed(b);
   assign prod_ext = {{EXT_W{prod[PROD_W-1]}}, prod};

   mac_pipe_reg #(.W(P_W), .EN(M_REG)) i_mreg (
      .clk (clk),
      .rst (rst_dat),
      .ce  (ce_dat),
      .d   (prod_ext),
      .q   (m)
   );

endmodule

// File: rtl/mac_postadd.sv
module mac_postadd
   import mac_slice_pkg::*;
#(
   parameter int P_W   = 48,
   parameter int SHIFT = 17
) (
   input  logic           clk,
   input  logic           rst_dat,
   input  logic           ce_dat,
   input  op_t            op,
   input  logic           cin,
   input  logic [P_W-1:0] m,
   input  logic [P_W-1:0] c,
   input  logic [P_W-1:0] pcin,
   output logic [P_W-1:0] p
);

   if (SHIFT < 1 || SHIFT >= P_W) begin : g_bad_shift
      $error("mac_postadd: SHIFT must lie in 1..P_W-1");
   end

   logic [P_W-1:0] x_opd, y_opd, z_opd, cin_w, pcin_shr, sum;

   assign pcin_shr = $signed(pcin) >>> SHIFT;
   assign cin_w    = {{(P_W-1){1'b0}}, cin};

   always_comb begin
      case (op.xsel)
         X_PROD:  x_opd = m;
         X_PFB:   x_opd = p;
         default: x_opd = '0;
      endcase
      y_opd = op.ysel ? c : '0;
      case (op.zsel)
         Z_PFB:      z_opd = p;
         Z_CASC:     z_opd = pcin;
         Z_CASC_SHR: z_opd = pcin_shr;
         default:    z_opd = '0;
      endcase
      if (op.sub) sum = z_opd - (x_opd + y_opd + cin_w);
      else        sum = z_opd + x_opd + y_opd + cin_w;
   end

   always_ff @(posedge clk) begin
      if (rst_dat)     p <= '0;
      else if (ce_dat) p <= sum;
   end

   logic armed = 1'b0;
   always_ff @(posedge clk) armed <= 1'b1;

   AST_CLEAR_ON_RESET: assert property (@(posedge clk)
      armed && $fell(rst_dat) |-> p == '0);  // R9

   AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst_dat || !armed)
      !ce_dat |=> $stable(p));  // R10

   AST_ACCUM_C: assert property (@(posedge clk) disable iff (rst_dat || !armed)
      ce_dat && op.xsel == X_PFB && op.ysel && op.zsel == Z_ZERO && !op.sub && !cin
      |=> p == $past(p) + $past(c));  // R3

   AST_CASCADE_SHIFT: assert property (@(posedge clk) disable iff (rst_dat || !armed)
      ce_dat && op.xsel == X_ZERO && !op.ysel && op.zsel == Z_CASC_SHR && !op.sub && !cin
      |=> $signed(p) == ($signed($past(pcin)) >>> SHIFT));  // R5

endmodule

// File: rtl/mac_slice.sv
module mac_slice
   import mac_slice_pkg::*;
#(
   parameter int A_W          = 18,
   parameter int B_W          = 18,
   parameter int P_W          = 48,
   parameter int SHIFT        = 17,
   parameter bit A_REG        = 1'b1,
   parameter bit B_REG        = 1'b1,
   parameter bit C_REG        = 1'b1,
   parameter bit M_REG        = 1'b1,
   parameter bit CTL_REG      = 1'b1,
   parameter bit B_FROM_CHAIN = 1'b0
) (
   input  logic           clk,
   input  logic           rst_ctl,
   input  logic           rst_dat,
   input  logic           ce_ctl,
   input  logic           ce_dat,
   input  logic [A_W-1:0] a,
   input  logic [B_W-1:0] b,
   input  logic [P_W-1:0] c,
   input  logic [B_W-1:0] bcin,
   input  logic [P_W-1:0] pcin,
   input  logic [5:0]     op,
   input  logic           cin,
   output logic [P_W-1:0] p,
   output logic [B_W-1:0] bcout,
   output logic [P_W-1:0] pcout
);

   if (A_W < 2 || B_W < 2) begin : g_bad_opw
      $error("mac_slice: operand widths must be at least 2");
   end
   if (P_W <= A_W + B_W) begin : g_bad_pw
      $error("mac_slice: P_W must exceed A_W + B_W");
   end
   if (OP_W != 6) begin : g_bad_op
      $error("mac_slice: operation word layout must be 6 bits");
   end

   logic [B_W-1:0] b_src;

   if (B_FROM_CHAIN) begin : g_b_chain
      logic unused_bits;
      assign unused_bits = ^b;
      assign b_src = bcin;
   end else begin : g_b_direct
      logic unused_bits;
      assign unused_bits = ^bcin;
      assign b_src = b;
   end

   logic [A_W-1:0]   a1;
   logic [B_W-1:0]   b1;
   logic [P_W-1:0]   c1, c2, m2;
   logic [CTL_W-1:0] ctl0, ctl1, ctl2;
   op_t              op2;

   assign ctl0 = {op, cin};

   mac_pipe_reg #(.W(A_W), .EN(A_REG)) i_areg (
      .clk(clk), .rst(rst_dat), .ce(ce_dat), .d(a), .q(a1));

   mac_pipe_reg #(.W(B_W), .EN(B_REG)) i_breg (
      .clk(clk), .rst(rst_dat), .ce(ce_dat), .d(b_src), .q(b1));

   mac_pipe_reg #(.W(P_W), .EN(C_REG)) i_creg1 (
      .clk(clk), .rst(rst_dat), .ce(ce_dat), .d(c), .q(c1));

   mac_pipe_reg #(.W(P_W), .EN(M_REG)) i_creg2 (
      .clk(clk), .rst(rst_dat), .ce(ce_dat), .d(c1), .q(c2));

   mac_pipe_reg #(.W(CTL_W), .EN(CTL_REG)) i_ctlreg1 (
      .clk(clk), .rst(rst_ctl), .ce(ce_ctl), .d(ctl0), .q(ctl1));

   mac_pipe_reg #(.W(CTL_W), .EN(M_REG)) i_ctlreg2 (
      .clk(clk), .rst(rst_ctl), .ce(ce_ctl), .d(ctl1), .q(ctl2));

   assign op2 = op_t'(ctl2[CTL_W-1:1]);

   mac_mult #(.A_W(A_W), .B_W(B_W), .P_W(P_W), .M_REG(M_REG)) i_mult (
      .clk     (clk),
      .rst_dat (rst_dat),
      .ce_dat  (ce_dat),
      .a       (a1),
      .b       (b1),
      .m       (m2)
   );

   mac_postadd #(.P_W(P_W), .SHIFT(SHIFT)) i_postadd (
      .clk     (clk),
      .rst_dat (rst_dat),
      .ce_dat  (ce_dat),
      .op      (op2),
      .cin     (ctl2[0]),
      .m       (m2),
      .c       (c2),
      .pcin    (pcin),
      .p       (p)
   );

   assign bcout = b1;
   assign pcout = p;

   logic armed = 1'b0;
   always_ff @(posedge clk) armed <= 1'b1;

   if (B_REG) begin : g_bchk
      AST_B_CHAIN_DELAY: assert property (@(posedge clk) disable iff (rst_dat || !armed)
         ce_dat |=> bcout == $past(b_src));  // R6
   end

endmodule

// File: tb/test_mac_slice.sv
`timescale 1ns/1ps
module test_mac_slice;

   typedef struct {
      logic [17:0] a;
      logic [17:0] b;
      logic [47:0] c;
      logic [47:0] pcin;
      logic [5:0]  op;
      logic        cin;
   } vec_t;

   localparam logic [5:0] XP = 6'd1, XF = 6'd2, YC = 6'd4;
   localparam logic [5:0] ZF = 6'd8, ZC = 6'd16, ZS = 6'd24, SB = 6'd32;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst = 1'b1, ce = 1'b1;
   logic [17:0] a = '0, b = '0, bcin = '0;
   logic [47:0] c = '0, pcin = '0;
   logic [5:0]  op = '0;
   logic        cin = 1'b0;
   logic [47:0] p, pcout;
   logic [17:0] bcout;

   mac_slice i_mac_slice (
      .clk(clk), .rst_ctl(rst), .rst_dat(rst), .ce_ctl(ce), .ce_dat(ce),
      .a(a), .b(b), .c(c), .bcin(bcin), .pcin(pcin), .op(op), .cin(cin),
      .p(p), .bcout(bcout), .pcout(pcout)
   );

   int          n_vec = 0, n_bad = 0;
   vec_t        hist[$];
   logic [47:0] pm = '0;
   logic [17:0] bm = '0;
   bit          done = 1'b0;

   function automatic vec_t zero_vec();
      vec_t v;
      v.a = '0; v.b = '0; v.c = '0; v.pcin = '0; v.op = '0; v.cin = 1'b0;
      return v;
   endfunction

   function automatic logic [47:0] model_next(vec_t o, logic [47:0] pc, logic [47:0] pold);
      longint prod, x, y, z, r;
      prod = longint'($signed(o.a)) * longint'($signed(o.b));
      case (o.op[1:0])
         2'd1: x = prod;
         2'd2: x = longint'($signed(pold));
         default: x = 0;
      endcase
      y = o.op[2] ? longint'($signed(o.c)) : 0;
      case (o.op[4:3])
         2'd1: z = longint'($signed(pold));
         2'd2: z = longint'($signed(pc));
         2'd3: z = longint'($signed(pc)) >>> 17;
         default: z = 0;
      endcase
      if (o.op[5]) r = z - (x + y + longint'(o.cin));
      else         r = z + x + y + longint'(o.cin);
      return r[47:0];
   endfunction

   function automatic vec_t rnd_vec(logic [5:0] opv);
      vec_t v;
      v.a = 18'($urandom); v.b = 18'($urandom);
      v.c = {16'($urandom), 32'($urandom)};
      v.pcin = {16'($urandom), 32'($urandom)};
      v.op = opv; v.cin = 1'($urandom);
      return v;
   endfunction

   task automatic check(string tag);
      n_vec++;
      if (p !== pm || pcout !== pm) begin
         n_bad++;
         $display("FAIL %s: p=%h pcout=%h expected %h", tag, p, pcout, pm);
      end
      if (bcout !== bm) begin
         n_bad++;
         $display("FAIL R6 (%s): bcout=%h expected %h", tag, bcout, bm);
      end
   endtask

   task automatic apply(vec_t v, logic r, logic e, string tag);
      vec_t o;
      a = v.a; b = v.b; c = v.c; pcin = v.pcin; op = v.op; cin = v.cin;
      bcin = ~v.b;
      rst = r; ce = e;
      @(posedge clk);
      if (r) begin
         hist.delete(); hist.push_back(zero_vec()); hist.push_back(zero_vec());
         pm = '0; bm = '0;
      end else if (e) begin
         o = hist.pop_front();
         pm = model_next(o, v.pcin, pm);
         hist.push_back(v);
         bm = v.b;
      end
      @(negedge clk);
      check(tag);
   endtask

   task automatic round_case(logic signed [17:0] av, logic signed [17:0] bv);
      vec_t   v;
      longint pr, q, got;
      pr = longint'(av) * longint'(bv);
      v = zero_vec();
      v.a = av; v.b = bv; v.c = 48'd7; v.op = XP | YC; v.cin = (pr < 0) ? 1'b0 : 1'b1;
      repeat (3) apply(v, 1'b0, 1'b1, "R8");
      q = ((pr < 0 ? -pr : pr) + 8) / 16;
      if (pr < 0) q = -q;
      got = longint'($signed(p)) >>> 4;
      n_vec++;
      if (got != q) begin
         n_bad++;
         $display("FAIL R8: rounded %0d expected %0d (product %0d)", got, q, pr);
      end
   endtask

   initial begin
      vec_t v;
      void'($urandom(32'd2718));
      hist.push_back(zero_vec()); hist.push_back(zero_vec());
      @(negedge clk);
      repeat (3) apply(zero_vec(), 1'b1, 1'b1, "R9");

      // R1: pure products including extremes
      v = zero_vec(); v.op = XP; v.a = 18'h20000; v.b = 18'h20000;
      apply(v, 1'b0, 1'b1, "R1");
      v.a = 18'h1FFFF; v.b = 18'h20000; apply(v, 1'b0, 1'b1, "R1");
      v.a = 18'h3FFFF; v.b = 18'h00005; apply(v, 1'b0, 1'b1, "R1");
      for (int i = 0; i < 12; i++) apply(rnd_vec(XP), 1'b0, 1'b1, "R1");

      // R2: three-input add and subtract
      for (int i = 0; i < 16; i++)
         apply(rnd_vec(XP | YC | (i[0] ? SB : 6'd0) | (i[1] ? ZC : 6'd0)), 1'b0, 1'b1, "R2");

      // R3: multiply-accumulate, then accumulate C
      for (int i = 0; i < 12; i++) apply(rnd_vec(XP | ZF), 1'b0, 1'b1, "R3");
      for (int i = 0; i < 8; i++)  apply(rnd_vec(XF | YC), 1'b0, 1'b1, "R3");
      for (int i = 0; i < 6; i++)  apply(rnd_vec(XP | ZF | SB), 1'b0, 1'b1, "R3");

      // R4, R5: cascade input unshifted and shifted
      for (int i = 0; i < 12; i++) apply(rnd_vec(XP | ZC), 1'b0, 1'b1, "R4");
      for (int i = 0; i < 12; i++) begin
         v = rnd_vec(i[0] ? ZS : (XP | ZS));
         v.pcin[47] = i[1];
         apply(v, 1'b0, 1'b1, "R5");
      end

      // R7: operation word changes every cycle
      for (int i = 0; i < 40; i++) apply(rnd_vec(6'($urandom)), 1'b0, 1'b1, "R7");
      v = zero_vec(); v.op = XP; v.a = 18'd3; v.b = 18'd7;
      apply(v, 1'b0, 1'b1, "R7");
      repeat (3) apply(zero_vec(), 1'b0, 1'b1, "R7");

      // R8: symmetric rounding, ties of both signs
      round_case(18'sd4, 18'sd6);
      round_case(-18'sd4, 18'sd6);
      round_case(-18'sd8, 18'sd1);
      round_case(18'sd8, 18'sd1);
      round_case(-18'sd9, 18'sd1);
      round_case(18'sd0, 18'sd5);
      round_case(18'sd40, 18'sd1);
      round_case(-18'sd40, 18'sd1);
      round_case(-18'sd1000, 18'sd77);

      // R10: enables low, inputs keep moving
      for (int i = 0; i < 4; i++) apply(rnd_vec(XP | ZF), 1'b0, 1'b1, "R10");
      for (int i = 0; i < 6; i++) apply(rnd_vec(6'($urandom)), 1'b0, 1'b0, "R10");
      for (int i = 0; i < 6; i++) apply(rnd_vec(XP | ZF), 1'b0, 1'b1, "R10");

      // R9: reset in mid-run, then quiet zero work
      apply(rnd_vec(XP), 1'b1, 1'b1, "R9");
      repeat (4) apply(zero_vec(), 1'b0, 1'b1, "R9");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule